// File: doc/BRIEF.md
# Direct-Mapped Longword Read Cache

This block is a small read cache placed between a 32-bit processor port and a slower memory port. It holds 256 bytes of data as 16 lines of four 32-bit longwords, indexed directly by address bits 7:4 with bits 3:2 picking the longword inside a line. Reads that hit are answered in the cycle the request is seen. Reads that miss go to memory either as one longword or, when burst filling is switched on, as four consecutive longword beats that fill the whole line. Writes always go straight to memory. A write also refreshes a copy that is already held in the cache, but it never brings a line in.

Software steers the cache through a 32-bit control register and a separate entry register, both reached through a simple register port. The control register turns the cache on and off, freezes its contents, turns burst filling on, and carries two write-one pulses. One pulse wipes every entry. The other wipes the single longword entry whose number is held in the entry register. Freezing keeps hits working but stops any miss from replacing data, so the contents behave like a read-only lookup table.

Top module: `lwc_read_cache`

## Requirements
- R1: After reset both registers read zero, no entry is valid, and neither `cpu_ack` nor `mem_req` is asserted.
- R2: While control bit 0 (enable) is 0, every read goes to memory as a single longword at the word-aligned request address, and nothing is stored; a repeated read goes to memory again.
- R3: While enable and control bit 1 (freeze) are both 1, hits are answered with no memory traffic. A miss is fetched as one longword and does not allocate or overwrite any line, even if burst is set.
- R4: With enable 1, freeze 0 and burst 0, a read miss fetches only the requested longword and marks only that longword valid. A later read of another longword in the same line still misses.
- R5: With enable 1, freeze 0 and control bit 4 (burst) 1, a read miss issues four memory reads at line base +0, +4, +8 and +12 in that order. It fills the line and returns the requested longword. Each memory request holds its address until `mem_ack`.
- R6: Writing a 1 to control bit 2 invalidates every entry of the cache at that write's clock edge.
- R7: Writing a 1 to control bit 3 invalidates only the longword entry given by the entry register. Entry bits 7:4 name the line and bits 3:2 name the longword. All other entries keep their contents.
- R8: `cfg_sel`=1 selects the entry register. Only written bits 7:2 are kept; all other bits are ignored and read back as zero.
- R9: `cfg_sel`=0 selects the control register. It reads back enable (bit 0), freeze (bit 1) and burst (bit 4). Bits 2 and 3 always read 0, and bits 31:5, including the whole upper half, always read 0.
- R10: A write is passed to memory as one write beat. If the longword is present in the cache, its copy is updated. A write miss allocates nothing, so a later read of that address misses.
- R11: A clear pulse (bit 2 or bit 3) in the same cycle as a fill beat wins. That beat is not stored, and the rest of that fill allocates nothing, but the requested data is still returned.
- R12: A read miss into a line that holds a different tag replaces the tag and invalidates the other longwords of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ack` |
| cpu_we | input | 1 | 1 for a write, 0 for a read |
| cpu_addr | input | 32 | Processor byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_ack | output | 1 | Request completes at this clock edge |
| cpu_rdata | output | 32 | Read data, valid with `cpu_ack` |
| mem_req | output | 1 | Memory beat request, held until `mem_ack` |
| mem_we | output | 1 | Memory write beat |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory beat completes at this edge |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects control register, 1 selects entry register |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Read value of the selected register |

## Verification
Reads are tried with the cache disabled, enabled with and without burst, and frozen. The number of memory beats per request, and their first and last addresses, separate a bypass from a single-longword fetch, a four-beat line fill and a hit. Two addresses that share a line index but differ in tag show whether replacement and per-longword validity work. Writes to a present and to an absent longword, each followed by a read, show the update and the no-allocate rule. Clear-all, clear-entry (with a masked entry value) and a clear timed onto the first fill beat are each followed by reads whose beat counts show exactly which entries survived.

// File: rtl/lwc_pkg.sv
package lwc_pkg;
    localparam int unsigned LW_W   = 32;
    localparam int unsigned CREG_W = 32;

    localparam int unsigned CB_ENABLE = 0;
    localparam int unsigned CB_FREEZE = 1;
    localparam int unsigned CB_WIPE   = 2;
    localparam int unsigned CB_ZAP    = 3;
    localparam int unsigned CB_BURST  = 4;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_READ,
        SQ_WRITE,
        SQ_DONE
    } seq_state_e;

    typedef struct packed {
        logic enable;
        logic freeze;
        logic burst;
    } ctrl_t;

    function automatic logic [CREG_W-1:0] ctrl_image(input ctrl_t c);
        logic [CREG_W-1:0] v;
        v = '0;
        v[CB_ENABLE] = c.enable;
        v[CB_FREEZE] = c.freeze;
        v[CB_BURST]  = c.burst;
        return v;
    endfunction
endpackage

// File: rtl/lwc_cfg.sv
module lwc_cfg
    import lwc_pkg::*;
#(
    parameter int unsigned ENT_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CREG_W-1:0] cfg_wdata,
    output logic [CREG_W-1:0] cfg_rdata,
    output ctrl_t             ctrl,
    output logic              wipe_all,
    output logic              zap_one,
    output logic [ENT_W-1:0]  zap_idx
);
    logic unused_hi;
    assign unused_hi = ^cfg_wdata[CREG_W-1:ENT_W+2];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl    <= '0;
            zap_idx <= '0;
        end else if (cfg_wr) begin
            if (!cfg_sel) begin
                ctrl.enable <= cfg_wdata[CB_ENABLE];
                ctrl.freeze <= cfg_wdata[CB_FREEZE];
                ctrl.burst  <= cfg_wdata[CB_BURST];
            end else begin
                zap_idx <= cfg_wdata[ENT_W+1:2];
            end
        end
    end

    assign wipe_all  = cfg_wr && !cfg_sel && cfg_wdata[CB_WIPE];
    assign zap_one   = cfg_wr && !cfg_sel && cfg_wdata[CB_ZAP];
    assign cfg_rdata = cfg_sel ? (CREG_W'(zap_idx) << 2) : ctrl_image(ctrl);
endmodule

// File: rtl/lwc_store.sv
module lwc_store
    import lwc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINES  = 16,
    parameter int unsigned WORDS  = 4,
    localparam int unsigned IDX_W = $clog2(LINES),
    localparam int unsigned OFF_W = $clog2(WORDS),
    localparam int unsigned ENT_W = IDX_W + OFF_W,
    localparam int unsigned TAG_W = ADDR_W - ENT_W - 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       lk_addr,
    output logic                    lk_hit,
    output logic [LW_W-1:0]         lk_data,
    input  logic                    fill_we,
    input  logic [ADDR_W-1:0]       fill_addr,
    input  logic [LW_W-1:0]         fill_data,
    input  logic                    upd_we,
    input  logic [ADDR_W-1:0]       upd_addr,
    input  logic [LW_W-1:0]         upd_data,
    input  logic                    wipe_all,
    input  logic                    zap_one,
    input  logic [ENT_W-1:0]        zap_idx,
    output logic [LINES*TAG_W-1:0]  tag_flat,
    output logic [LINES*WORDS-1:0]  vld_flat
);
    logic [TAG_W-1:0] tag_q [LINES];
    logic [WORDS-1:0] vld_q [LINES];
    logic [LW_W-1:0]  dat_q [LINES][WORDS];

    logic unused_lo;
    assign unused_lo = ^{lk_addr[1:0], fill_addr[1:0], upd_addr[1:0]};

    logic [IDX_W-1:0] l_i, f_i, u_i, z_i;
    logic [OFF_W-1:0] l_o, f_o, u_o, z_o;
    logic [TAG_W-1:0] l_t, f_t, u_t;

    assign l_i = lk_addr[2+OFF_W +: IDX_W];
    assign l_o = lk_addr[2 +: OFF_W];
    assign l_t = lk_addr[ADDR_W-1 -: TAG_W];
    assign f_i = fill_addr[2+OFF_W +: IDX_W];
    assign f_o = fill_addr[2 +: OFF_W];
    assign f_t = fill_addr[ADDR_W-1 -: TAG_W];
    assign u_i = upd_addr[2+OFF_W +: IDX_W];
    assign u_o = upd_addr[2 +: OFF_W];
    assign u_t = upd_addr[ADDR_W-1 -: TAG_W];
    assign z_i = zap_idx[OFF_W +: IDX_W];
    assign z_o = zap_idx[0 +: OFF_W];

    assign lk_hit  = vld_q[l_i][l_o] && (tag_q[l_i] == l_t);
    assign lk_data = dat_q[l_i][l_o];

    logic any_clear, fill_ok, upd_hit;
    assign any_clear = wipe_all || zap_one;
    assign fill_ok   = fill_we && !any_clear;
    assign upd_hit   = upd_we && vld_q[u_i][u_o] && (tag_q[u_i] == u_t);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < LINES; i++) begin
                vld_q[i] <= '0;
                tag_q[i] <= '0;
            end
        end else if (wipe_all) begin
            for (int i = 0; i < LINES; i++) vld_q[i] <= '0;
        end else if (zap_one) begin
            vld_q[z_i][z_o] <= 1'b0;
        end else if (fill_ok) begin
            if (tag_q[f_i] == f_t) begin
                vld_q[f_i][f_o] <= 1'b1;
            end else begin
                tag_q[f_i] <= f_t;
                vld_q[f_i] <= WORDS'(1) << f_o;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (fill_ok) dat_q[f_i][f_o] <= fill_data;
        if (upd_hit) dat_q[u_i][u_o] <= upd_data;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_flat
        assign tag_flat[g*TAG_W +: TAG_W] = tag_q[g];
        assign vld_flat[g*WORDS +: WORDS] = vld_q[g];
    end
endmodule

// File: rtl/lwc_seq.sv
module lwc_seq
    import lwc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned OFF_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  ctrl_t             ctrl,
    input  logic              any_clear,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [LW_W-1:0]   cpu_wdata,
    output logic              cpu_ack,
    output logic [LW_W-1:0]   cpu_rdata,
    input  logic              lk_hit,
    input  logic [LW_W-1:0]   lk_data,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LW_W-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [LW_W-1:0]   mem_rdata,
    output logic              fill_we,
    output logic              upd_we,
    output logic              idle
);
    seq_state_e        st_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LW_W-1:0]   wdata_q, buf_q;
    logic [OFF_W-1:0]  beat_q;
    logic              alloc_q, burst_q, kill_q;

    logic unused_lo;
    assign unused_lo = ^addr_q[1:0];

    logic hit_now, last_beat, may_alloc, go_burst;
    assign idle      = (st_q == SQ_IDLE);
    assign hit_now   = idle && cpu_req && !cpu_we && ctrl.enable && lk_hit;
    assign may_alloc = ctrl.enable && !ctrl.freeze;
    assign go_burst  = may_alloc && ctrl.burst && !cpu_we;
    assign last_beat = !burst_q || (beat_q == OFF_W'(2**OFF_W - 1));

    assign cpu_ack   = hit_now || (st_q == SQ_DONE);
    assign cpu_rdata = (st_q == SQ_DONE) ? buf_q : lk_data;
    assign mem_req   = (st_q == SQ_READ) || (st_q == SQ_WRITE);
    assign mem_we    = (st_q == SQ_WRITE);
    assign mem_addr  = {addr_q[ADDR_W-1:OFF_W+2], beat_q, 2'b00};
    assign mem_wdata = wdata_q;
    assign fill_we   = (st_q == SQ_READ) && mem_ack && alloc_q && !kill_q
                       && !any_clear && may_alloc;
    assign upd_we    = (st_q == SQ_WRITE) && mem_ack && ctrl.enable;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= SQ_IDLE;
            addr_q  <= '0;
            wdata_q <= '0;
            buf_q   <= '0;
            beat_q  <= '0;
            alloc_q <= 1'b0;
            burst_q <= 1'b0;
            kill_q  <= 1'b0;
        end else begin
            unique case (st_q)
                SQ_IDLE: if (cpu_req && !hit_now) begin
                    addr_q  <= cpu_addr;
                    wdata_q <= cpu_wdata;
                    kill_q  <= 1'b0;
                    alloc_q <= may_alloc && !cpu_we;
                    burst_q <= go_burst;
                    beat_q  <= go_burst ? '0 : cpu_addr[2 +: OFF_W];
                    st_q    <= cpu_we ? SQ_WRITE : SQ_READ;
                end
                SQ_READ: begin
                    if (any_clear) kill_q <= 1'b1;
                    if (mem_ack) begin
                        if (beat_q == addr_q[2 +: OFF_W]) buf_q <= mem_rdata;
                        if (last_beat) st_q <= SQ_DONE;
                        else beat_q <= beat_q + 1'b1;
                    end
                end
                SQ_WRITE: if (mem_ack) st_q <= SQ_DONE;
                SQ_DONE:  st_q <= SQ_IDLE;
                default:  st_q <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/lwc_read_cache.sv
module lwc_read_cache
    import lwc_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LINES  = 16,
    parameter int unsigned WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [LW_W-1:0]   cpu_wdata,
    output logic              cpu_ack,
    output logic [LW_W-1:0]   cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LW_W-1:0]   mem_wdata,
    input  logic              mem_ack,
    input  logic [LW_W-1:0]   mem_rdata,
    input  logic              cfg_wr,
    input  logic              cfg_sel,
    input  logic [CREG_W-1:0] cfg_wdata,
    output logic [CREG_W-1:0] cfg_rdata
);
    localparam int unsigned IDX_W    = $clog2(LINES);
    localparam int unsigned OFF_W    = $clog2(WORDS);
    localparam int unsigned ENT_W    = IDX_W + OFF_W;
    localparam int unsigned TAG_W    = ADDR_W - ENT_W - 2;
    localparam int unsigned VLD_BITS = LINES * WORDS;
    localparam int unsigned TAG_BITS = LINES * TAG_W;

    ctrl_t              ctrl;
    logic               wipe_all, zap_one, any_clear;
    logic [ENT_W-1:0]   zap_idx;
    logic               lk_hit, fill_we, upd_we, seq_idle;
    logic [LW_W-1:0]    lk_data;
    logic [TAG_BITS-1:0] tag_flat;
    logic [VLD_BITS-1:0] vld_flat;

    assign any_clear = wipe_all || zap_one;

    lwc_cfg #(.ENT_W(ENT_W)) u_cfg (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .ctrl(ctrl),
        .wipe_all(wipe_all), .zap_one(zap_one), .zap_idx(zap_idx)
    );

    lwc_store #(.ADDR_W(ADDR_W), .LINES(LINES), .WORDS(WORDS)) u_store (
        .clk(clk), .rst(rst), .lk_addr(cpu_addr), .lk_hit(lk_hit),
        .lk_data(lk_data), .fill_we(fill_we), .fill_addr(mem_addr),
        .fill_data(mem_rdata), .upd_we(upd_we), .upd_addr(mem_addr),
        .upd_data(mem_wdata), .wipe_all(wipe_all), .zap_one(zap_one),
        .zap_idx(zap_idx), .tag_flat(tag_flat), .vld_flat(vld_flat)
    );

    lwc_seq #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_seq (
        .clk(clk), .rst(rst), .ctrl(ctrl), .any_clear(any_clear),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack), .cpu_rdata(cpu_rdata),
        .lk_hit(lk_hit), .lk_data(lk_data), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .fill_we(fill_we),
        .upd_we(upd_we), .idle(seq_idle)
    );
endmodule

// File: rtl/lwc_read_cache_chk.sv
module lwc_read_cache_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned VW = 64,
    parameter int unsigned TW = 384
) (
    input logic          clk,
    input logic          rst,
    input logic          cfg_wr,
    input logic          cfg_sel,
    input logic [31:0]   cfg_wdata,
    input logic [31:0]   cfg_rdata,
    input logic          cpu_req,
    input logic          cpu_ack,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic          en,
    input logic          frz,
    input logic          seq_idle,
    input logic [VW-1:0] vld_flat,
    input logic [TW-1:0] tag_flat
);
    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!cpu_ack && !mem_req && vld_flat == '0)); // R1
    AST_BYPASS_NO_HIT: assert property (@(posedge clk) disable iff (rst)
        (seq_idle && cpu_req && !en) |-> !cpu_ack); // R2
    AST_FREEZE_KEEPS_TAGS: assert property (@(posedge clk) disable iff (rst)
        (en && frz) |=> $stable(tag_flat)); // R3
    AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R5
    AST_WIPE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && !cfg_sel && cfg_wdata[2]) |=> (vld_flat == '0)); // R6
    AST_ENTRY_MASKED: assert property (@(posedge clk) disable iff (rst)
        cfg_sel |-> (cfg_rdata[1:0] == 2'b00 && cfg_rdata[31:8] == '0)); // R8
    AST_CTRL_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        !cfg_sel |-> (cfg_rdata[31:16] == '0 && cfg_rdata[3:2] == 2'b00)); // R9
endmodule

bind lwc_read_cache lwc_read_cache_chk #(
    .AW(ADDR_W), .VW(VLD_BITS), .TW(TAG_BITS)
) u_chk (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .cpu_req(cpu_req),
    .cpu_ack(cpu_ack), .mem_req(mem_req), .mem_ack(mem_ack),
    .mem_addr(mem_addr), .en(ctrl.enable), .frz(ctrl.freeze),
    .seq_idle(seq_idle), .vld_flat(vld_flat), .tag_flat(tag_flat)
);

// File: tb/lwc_read_cache_test.sv
`timescale 1ns/1ps
module lwc_read_cache_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [31:0] cpu_addr = '0, cpu_wdata = '0;
    logic        cpu_ack;
    logic [31:0] cpu_rdata;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_rdata = '0;
    logic        cfg_wr = 1'b0, cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;

    always #2.5 clk = ~clk;

    lwc_read_cache uut (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ack(cpu_ack),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
        .mem_rdata(mem_rdata), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    typedef struct {
        string       rq;
        bit          cmp_data;
        logic [31:0] data;
        int          beats;
        logic [31:0] first;
        logic [31:0] last;
    } exp_t;
    exp_t exp_q[$];

    logic [31:0] mem_img [logic [31:0]];

    function automatic logic [31:0] mval(input logic [31:0] a);
        logic [31:0] w;
        w = {a[31:2], 2'b00};
        if (mem_img.exists(w)) return mem_img[w];
        return {w[15:0] ^ 16'hC3A5, w[15:0]};
    endfunction

    task automatic check(input bit ok, input string rq, input logic [31:0] act,
                         input logic [31:0] exp, input string what);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // memory model: two-cycle latency per beat
    int wcnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0;
            wcnt    <= 0;
        end else if (mem_ack) begin
            mem_ack <= 1'b0;
        end else if (mem_req) begin
            if (wcnt == 1) begin
                wcnt    <= 0;
                mem_ack <= 1'b1;
                if (mem_we) mem_img[{mem_addr[31:2], 2'b00}] = mem_wdata;
                else mem_rdata <= mval(mem_addr);
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    // monitor: counts memory beats and compares each completed request
    int nb = 0;
    logic [31:0] fa = '0, la = '0;
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            if (mem_ack) begin
                if (nb == 0) fa = mem_addr;
                la = mem_addr;
                nb++;
            end
            if (cpu_req && cpu_ack) begin
                exp_t e;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R?", 32'd1, 32'd0, "unexpected completion");
                end else begin
                    e = exp_q.pop_front();
                    if (e.cmp_data) check(cpu_rdata == e.data, e.rq, cpu_rdata, e.data, "read data");
                    check(nb == e.beats, e.rq, nb, e.beats, "memory beats");
                    if (e.beats > 0) begin
                        check(fa == e.first, e.rq, fa, e.first, "first beat address");
                        check(la == e.last, e.rq, la, e.last, "last beat address");
                    end
                end
                nb = 0;
            end
        end
    end

    task automatic xfer(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input string rq, input int beats);
        exp_t e;
        e.rq = rq;
        e.cmp_data = !we;
        e.data = we ? 32'd0 : mval(a);
        e.beats = beats;
        if (beats == 4) begin
            e.first = {a[31:4], 4'h0};
            e.last  = e.first + 32'd12;
        end else begin
            e.first = {a[31:2], 2'b00};
            e.last  = e.first;
        end
        exp_q.push_back(e);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
        #1;
        while (!cpu_ack) begin
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, input string rq, input int beats);
        xfer(1'b0, a, 32'd0, rq, beats);
    endtask

    task automatic cfg_write(input bit sel, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0; cfg_wdata = '0;
    endtask

    task automatic cfg_check(input bit sel, input logic [31:0] e, input string rq);
        @(negedge clk);
        cfg_sel = sel;
        #1;
        check(cfg_rdata == e, rq, cfg_rdata, e, "register readback");
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        cfg_check(1'b0, 32'h0, "R1");
        cfg_check(1'b1, 32'h0, "R1");
        check(!cpu_ack && !mem_req, "R1", {cpu_ack, mem_req}, 32'd0, "idle outputs");

        // R2 disabled: bypass each time
        rd(32'h100, "R2", 1);
        rd(32'h100, "R2", 1);

        // R4 single-longword fills
        cfg_write(1'b0, 32'h01);
        rd(32'h104, "R4", 1);
        rd(32'h104, "R4", 0);
        rd(32'h108, "R4", 1);

        // R5 burst fill of a line
        cfg_write(1'b0, 32'h11);
        rd(32'h208, "R5", 4);
        rd(32'h200, "R5", 0);
        rd(32'h20C, "R5", 0);

        // R12 tag conflict on line 0
        rd(32'h1200, "R12", 4);
        rd(32'h200, "R12", 4);

        // R3 freeze: hits served, misses single and not stored
        cfg_write(1'b0, 32'h13);
        rd(32'h204, "R3", 0);
        rd(32'h300, "R3", 1);
        rd(32'h300, "R3", 1);
        rd(32'h204, "R3", 0);

        // R10 write-through
        cfg_write(1'b0, 32'h11);
        xfer(1'b1, 32'h204, 32'hDEAD0204, "R10", 1);
        rd(32'h204, "R10", 0);
        xfer(1'b1, 32'h400, 32'hBEEF0400, "R10", 1);
        rd(32'h400, "R10", 4);

        // R6 clear all
        rd(32'h510, "R6", 4);
        rd(32'h514, "R6", 0);
        cfg_write(1'b0, 32'h15);
        cfg_check(1'b0, 32'h11, "R9");
        rd(32'h514, "R6", 4);

        // R7 / R8 clear one entry
        rd(32'h520, "R7", 4);
        cfg_write(1'b1, 32'hFFFF_FF2B);
        cfg_check(1'b1, 32'h28, "R8");
        cfg_write(1'b0, 32'h19);
        rd(32'h520, "R7", 0);
        rd(32'h524, "R7", 0);
        rd(32'h510, "R7", 0);
        rd(32'h528, "R7", 4);
        rd(32'h52C, "R7", 0);

        // R9 register layout with all bits written
        cfg_write(1'b0, 32'hFFFF_FFFF);
        cfg_check(1'b0, 32'h13, "R9");
        cfg_write(1'b0, 32'h11);
        cfg_check(1'b0, 32'h11, "R9");
        rd(32'h510, "R9", 4);

        // R11 clear on the first fill beat wins
        fork
            rd(32'h640, "R11", 4);
            begin
                wait (mem_ack == 1'b1);
                cfg_write(1'b0, 32'h15);
            end
        join
        rd(32'h644, "R11", 4);
        rd(32'h648, "R11", 0);

        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R1", exp_q.size(), 32'd0, "pending completions");
        finished = 1;
        summary();
        $finish;
    end
endmodule